// File: doc/BRIEF.md
# Absolute Encoder Frame Reader with CRC Check

This block is a serial master that fetches one fixed-length position frame from an absolute encoder over three wires. The wires are an active-low select, a master clock and a return data line from the sensor. A one-cycle request starts a read. The block then drives select low and sends a fixed number of clock pulses. On each rising clock edge it captures one bit from the encoder: a leading marker bit, the status field, the position word, and a trailing check code. The link only carries data from the encoder to the master, so the master sends no commands.

When the last pulse has been sent, the block releases select. It checks the received check code against one it computed over the status and position bits as they arrived. It then raises a one-cycle completion strobe with a check result flag and a framing flag. A frame that fails either test is dropped, and the position and status outputs keep the values of the last good frame. After each frame the block enforces a minimum idle time before it accepts the next request.

Top module: `enc_frame_reader`

## Requirements
- R1: While no frame is in progress, cs_n_o is 1 and ma_o is 1.
- R2: A start_i seen high at a clock edge while the reader is idle and the idle guard has expired is accepted, and cs_n_o is 0 from the following cycle until the end of the frame.
- R3: After acceptance, ma_o stays high for HALF_DIV cycles. It then makes exactly FRAME_LEN = 1+STAT_W+POS_W+CRC_W pulses, each low for HALF_DIV cycles and then high for HALF_DIV cycles.
- R4: slo_i is captured at each rising edge of ma_o. The bits are taken in this order: marker bit, status (MSB first), position (MSB first), check code (MSB first).
- R5: The check code is the remainder of the polynomial x^6+x+1 (CRC_POLY=6'h03), computed with a zero start value, MSB first, over status followed by position. The frame passes (crc_ok_o=1) when this remainder equals the bitwise inverse of the received code.
- R6: frame_err_o is 1 for a frame whose marker bit was captured as 0.
- R7: One cycle after the last high phase, done_o is 1 for exactly one cycle, cs_n_o and ma_o are 1 in that cycle, and crc_ok_o and frame_err_o hold that frame's results.
- R8: pos_o and stat_o take the received values only when crc_ok_o=1 and frame_err_o=0. Otherwise they keep their previous values.
- R9: For IDLE_CYC cycles after the done cycle, and during a frame, start_i is ignored. A start_i held high is accepted on the first cycle after the guard expires.
- R10: After reset, pos_o, stat_o, crc_ok_o, frame_err_o and done_o are 0, and cs_n_o and ma_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to read one frame |
| slo_i | input | 1 | Serial data returned by the encoder |
| cs_n_o | output | 1 | Active-low encoder select |
| ma_o | output | 1 | Master clock to the encoder, idles high |
| done_o | output | 1 | One-cycle strobe at frame end |
| pos_o | output | POS_W | Position from the last good frame |
| stat_o | output | STAT_W | Status from the last good frame |
| crc_ok_o | output | 1 | Check code of the last frame matched |
| frame_err_o | output | 1 | Marker bit of the last frame was 0 |

## Verification
The hardest cases to reach are a bad frame arriving right after a good one, where the outputs must keep the older values, and a request that arrives exactly when the idle guard expires. The bench acts as the encoder. It builds each frame with its own long-division remainder, and can flip a single data bit, a code bit or the marker bit. It also holds start_i high across consecutive frames, so that a request lands on the first cycle the guard allows. A behavioural model predicts the select, clock, strobe and result outputs for every cycle, and the bench compares them with the design.

// File: rtl/enc_rd_pkg.sv
// Package: shared types for the encoder frame reader.
// Assumes: nothing beyond IEEE 1800-2017.
package enc_rd_pkg;

    // Reader sequencing states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_DONE  = 3'd4
    } rd_state_t;

endpackage

// File: rtl/enc_rd_shift.sv
// Module: serial-in shift register that gathers the whole frame, newest bit
// at bit 0. Assumes: en_i pulses once per received bit; earlier content is
// overwritten in full by each frame.
module enc_rd_shift #(
    parameter int W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);

    // Shift in one sampled bit per enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (en_i) begin
            data_o <= {data_o[W-2:0], bit_i};
        end
    end

endmodule

// File: rtl/enc_rd_crc.sv
// Module: bit-serial CRC accumulator, MSB first, with zero start value.
// Assumes: clr_i is held while idle; en_i pulses once per payload bit.
module enc_rd_crc #(
    parameter int           W    = 6,
    parameter logic [W-1:0] POLY = 6'h03
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);

    logic fb;
    assign fb = crc_o[W-1] ^ bit_i;

    // Update the remainder with one payload bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            crc_o <= '0;
        end else if (en_i) begin
            crc_o <= {crc_o[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

endmodule

// File: rtl/enc_frame_reader.sv
// Module: master that reads one fixed-length absolute-encoder frame.
// It sends FRAME_LEN clock pulses with select held low and samples slo_i on
// each rising ma_o. It checks the trailing code, which arrives inverted, and
// keeps position and status only from good frames.
// Assumes: HALF_DIV >= 1; the encoder changes slo_i after a falling ma_o.
module enc_frame_reader #(
    parameter int                STAT_W   = 2,
    parameter int                POS_W    = 26,
    parameter int                CRC_W    = 6,
    parameter logic [CRC_W-1:0]  CRC_POLY = 6'h03,
    parameter int                HALF_DIV = 2,
    parameter int                IDLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              slo_i,
    output logic              cs_n_o,
    output logic              ma_o,
    output logic              done_o,
    output logic [POS_W-1:0]  pos_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              crc_ok_o,
    output logic              frame_err_o
);
    import enc_rd_pkg::*;

    localparam int PAY_W     = STAT_W + POS_W;
    localparam int FRAME_LEN = 1 + PAY_W + CRC_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int HC_W      = $clog2(HALF_DIV + 1);
    localparam int GD_W      = $clog2(IDLE_CYC + 1);

    rd_state_t            state, nxt;
    logic [HC_W-1:0]      hcnt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [GD_W-1:0]      guard;
    logic                 hcnt_last, sample, crc_en, crc_clr;
    logic [FRAME_LEN-1:0] frame_q;
    logic [CRC_W-1:0]     crc_calc, rx_crc;
    logic                 start_bit, crc_match;

    assign hcnt_last = (hcnt == HC_W'(HALF_DIV - 1));
    assign sample    = (state == ST_LOW) && hcnt_last;
    assign crc_en    = sample && (bit_cnt != '0) && (bit_cnt <= CNT_W'(PAY_W));
    assign crc_clr   = (state == ST_IDLE);
    assign start_bit = frame_q[FRAME_LEN-1];
    assign rx_crc    = frame_q[CRC_W-1:0];
    assign crc_match = (crc_calc == ~rx_crc);

    // Next-state decode for the frame sequence
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (start_i && guard == '0) nxt = ST_SETUP;
            ST_SETUP: if (hcnt_last) nxt = ST_LOW;
            ST_LOW:   if (hcnt_last) nxt = ST_HIGH;
            ST_HIGH:  if (hcnt_last)
                          nxt = (bit_cnt == CNT_W'(FRAME_LEN)) ? ST_DONE : ST_LOW;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State, phase counter and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hcnt    <= '0;
            bit_cnt <= '0;
        end else begin
            state   <= nxt;
            hcnt    <= (state == ST_IDLE || state != nxt) ? '0 : hcnt + 1'b1;
            if (state == ST_IDLE)
                bit_cnt <= '0;
            else if (sample)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Idle guard after each frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            guard <= '0;
        else if (state == ST_DONE)
            guard <= GD_W'(IDLE_CYC);
        else if (state == ST_IDLE && guard != '0)
            guard <= guard - 1'b1;
    end

    // Registered link pins derived from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o <= 1'b1;
            ma_o   <= 1'b1;
        end else begin
            cs_n_o <= (nxt == ST_IDLE) || (nxt == ST_DONE);
            ma_o   <= (nxt != ST_LOW);
        end
    end

    // Result latch: flags every frame, data only from good frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            crc_ok_o    <= 1'b0;
            frame_err_o <= 1'b0;
            pos_o       <= '0;
            stat_o      <= '0;
        end else begin
            done_o <= (nxt == ST_DONE);
            if (nxt == ST_DONE) begin
                crc_ok_o    <= crc_match;
                frame_err_o <= !start_bit;
                if (crc_match && start_bit) begin
                    pos_o  <= frame_q[CRC_W +: POS_W];
                    stat_o <= frame_q[CRC_W+POS_W +: STAT_W];
                end
            end
        end
    end

    enc_rd_shift #(.W(FRAME_LEN)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (sample),
        .bit_i  (slo_i),
        .data_o (frame_q)
    );

    enc_rd_crc #(.W(CRC_W), .POLY(CRC_POLY)) crc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (crc_clr),
        .en_i   (crc_en),
        .bit_i  (slo_i),
        .crc_o  (crc_calc)
    );

    // R1: clock idles high whenever select is released
    p_idle_clk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> ma_o);

    // R2: select only falls after an observed request
    p_cs_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(start_i));

    // R3: a frame ends only after all pulses were counted
    p_pulse_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> bit_cnt == CNT_W'(FRAME_LEN));

    // R4: every capture coincides with a rising master clock
    p_sample_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> $rose(ma_o));

    // R7: done is a single-cycle strobe with select released
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o ##1 (!done_o && cs_n_o));

    // R8: a rejected frame leaves the held position unchanged
    p_hold_on_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (!crc_ok_o || frame_err_o)) |-> $stable(pos_o) && $stable(stat_o));

endmodule

// File: tb/enc_frame_reader_tb_top.sv
// Bench: plays the encoder, predicts every output cycle by cycle with a
// behavioural model, and compares on each falling clock edge.
module enc_frame_reader_tb_top;

    localparam int STAT_W    = 2;
    localparam int POS_W     = 26;
    localparam int CRC_W     = 6;
    localparam logic [CRC_W-1:0] POLY = 6'h03;
    localparam int HALF_DIV  = 2;
    localparam int IDLE_CYC  = 8;
    localparam int PAY_W     = STAT_W + POS_W;
    localparam int FRAME_LEN = 1 + PAY_W + CRC_W;
    localparam int ACT_CYC   = HALF_DIV * (1 + 2 * FRAME_LEN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic slo_i = 1'b1;
    logic cs_n_o, ma_o, done_o, crc_ok_o, frame_err_o;
    logic [POS_W-1:0]  pos_o;
    logic [STAT_W-1:0] stat_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    enc_frame_reader #(
        .STAT_W(STAT_W), .POS_W(POS_W), .CRC_W(CRC_W), .CRC_POLY(POLY),
        .HALF_DIV(HALF_DIV), .IDLE_CYC(IDLE_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .slo_i(slo_i),
        .cs_n_o(cs_n_o), .ma_o(ma_o), .done_o(done_o), .pos_o(pos_o),
        .stat_o(stat_o), .crc_ok_o(crc_ok_o), .frame_err_o(frame_err_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Remainder by long division of payload * x^CRC_W
    function automatic logic [CRC_W-1:0] crc_div(input logic [PAY_W-1:0] d);
        logic [PAY_W+CRC_W-1:0] r;
        r = {d, {CRC_W{1'b0}}};
        for (int i = PAY_W + CRC_W - 1; i >= CRC_W; i--)
            if (r[i]) r[i -: CRC_W+1] = r[i -: CRC_W+1] ^ {1'b1, POLY};
        return r[CRC_W-1:0];
    endfunction

    // Encoder model: next bit after every falling master clock
    logic [FRAME_LEN-1:0] tx_frame = '0;
    int sidx = 0;
    always @(negedge ma_o) if (!cs_n_o) begin
        slo_i = tx_frame[FRAME_LEN-1-sidx];
        sidx++;
    end
    always @(posedge cs_n_o) sidx = 0;

    // Reference model of the reader's timing and results
    typedef enum int {M_IDLE, M_ACT, M_DONE} mmode_t;
    mmode_t mmode = M_IDLE;
    int m = 0;
    int guard = 0;
    bit e_ok = 0, e_ferr = 0;
    logic [POS_W-1:0]  e_pos = '0;
    logic [STAT_W-1:0] e_stat = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mmode = M_IDLE; guard = 0; m = 0;
            e_ok = 0; e_ferr = 0; e_pos = '0; e_stat = '0;
        end else begin
            case (mmode)
                M_IDLE: if (guard > 0) guard--;
                        else if (start_i) begin mmode = M_ACT; m = 0; end
                M_ACT: begin
                    m++;
                    if (m == ACT_CYC) begin
                        logic [PAY_W-1:0] pay;
                        pay    = tx_frame[FRAME_LEN-2 -: PAY_W];
                        e_ok   = (crc_div(pay) == ~tx_frame[CRC_W-1:0]);
                        e_ferr = !tx_frame[FRAME_LEN-1];
                        if (e_ok && !e_ferr) begin
                            e_pos  = pay[POS_W-1:0];
                            e_stat = pay[PAY_W-1 -: STAT_W];
                        end
                        mmode = M_DONE;
                    end
                end
                default: begin mmode = M_IDLE; guard = IDLE_CYC; end
            endcase
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) if (rst_n && !finished) begin
        case (mmode)
            M_IDLE: begin
                chk(cs_n_o == 1'b1, "R9 cs_n idle/guard", cs_n_o, 1);
                chk(ma_o == 1'b1, "R1 ma idle", ma_o, 1);
                chk(done_o == 1'b0, "R7 done idle", done_o, 0);
            end
            M_ACT: begin
                bit e_ma;
                if (m < HALF_DIV) e_ma = 1'b1;
                else e_ma = (((m - HALF_DIV) % (2 * HALF_DIV)) >= HALF_DIV);
                chk(cs_n_o == 1'b0, "R2 cs_n active", cs_n_o, 0);
                chk(ma_o == e_ma, "R3 ma pulse", ma_o, e_ma);
                chk(done_o == 1'b0, "R7 done active", done_o, 0);
            end
            default: begin
                chk(done_o == 1'b1, "R7 done strobe", done_o, 1);
                chk(cs_n_o == 1'b1 && ma_o == 1'b1, "R7 pins at done", {cs_n_o, ma_o}, 3);
                chk(crc_ok_o == e_ok, "R5 crc_ok", crc_ok_o, e_ok);
                chk(frame_err_o == e_ferr, "R6 frame_err", frame_err_o, e_ferr);
            end
        endcase
        chk(pos_o == e_pos, "R8 pos", pos_o, e_pos);
        chk(stat_o == e_stat, "R8 stat", stat_o, e_stat);
    end

    function automatic logic [FRAME_LEN-1:0] build(input bit sb, input logic [STAT_W-1:0] st,
                                                   input logic [POS_W-1:0] p);
        return {sb, st, p, ~crc_div({st, p})};
    endfunction

    // Issue one read; optional extra request in the middle of the frame
    task automatic run_frame(input logic [FRAME_LEN-1:0] f, input bit poke_mid);
        tx_frame = f;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        repeat (ACT_CYC + IDLE_CYC + 6) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [POS_W-1:0] rp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values
        chk(pos_o == '0 && stat_o == '0, "R10 data reset", pos_o, 0);
        chk(!done_o && !crc_ok_o && !frame_err_o, "R10 flags reset", {done_o, crc_ok_o, frame_err_o}, 0);
        chk(cs_n_o && ma_o, "R10 pins reset", {cs_n_o, ma_o}, 3);

        // R4/R5: good frames with distinct patterns
        run_frame(build(1'b1, 2'b00, '0), 1'b0);
        run_frame(build(1'b1, 2'b11, '1), 1'b0);
        chk(pos_o == '1 && stat_o == 2'b11, "R4 all ones", pos_o, 26'h3ffffff);
        run_frame(build(1'b1, 2'b10, 26'h2aaaaaa), 1'b0);
        chk(pos_o == 26'h2aaaaaa && stat_o == 2'b10, "R4 alternating", pos_o, 26'h2aaaaaa);
        run_frame(build(1'b1, 2'b01, 26'h0000001), 1'b1);   // R9 mid-frame request ignored
        chk(pos_o == 26'h1 && stat_o == 2'b01, "R4 lsb only", pos_o, 1);
        for (int k = 0; k < 4; k++) begin
            rp = POS_W'($urandom);
            run_frame(build(1'b1, STAT_W'(k), rp), 1'b0);
            chk(pos_o == rp, "R4 random position", pos_o, rp);
        end

        // R5/R8: bad check code, flipped data bit, flipped code bit
        rp = pos_o;
        run_frame(build(1'b1, 2'b11, 26'h1234567) ^ {{(FRAME_LEN-1){1'b0}}, 1'b1}, 1'b0);
        chk(!crc_ok_o && pos_o == rp, "R8 hold after code error", pos_o, rp);
        run_frame(build(1'b1, 2'b01, 26'h0abcdef) ^ (FRAME_LEN'(1) << (CRC_W + 9)), 1'b0);
        chk(!crc_ok_o && pos_o == rp, "R5 data bit flip caught", pos_o, rp);

        // R6: marker bit 0 with an otherwise correct code
        run_frame(build(1'b0, 2'b10, 26'h3000000), 1'b0);
        chk(frame_err_o && pos_o == rp, "R6 marker error held", pos_o, rp);

        // R9: request held high, frames start right at guard expiry
        tx_frame = build(1'b1, 2'b10, 26'h155aa55);
        @(negedge clk) start_i = 1'b1;
        repeat (3 * (ACT_CYC + IDLE_CYC + 1)) @(negedge clk);
        start_i = 1'b0;
        repeat (ACT_CYC + IDLE_CYC + 6) @(negedge clk);
        chk(pos_o == 26'h155aa55, "R9 back-to-back result", pos_o, 26'h155aa55);

        // Good frame after errors restores updating
        run_frame(build(1'b1, 2'b00, 26'h0f0f0f0), 1'b0);
        chk(crc_ok_o && !frame_err_o && pos_o == 26'h0f0f0f0, "R8 update after recovery", pos_o, 26'h0f0f0f0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule